// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block sits beside a 13-bit-address static memory array and watches its read traffic for a command that software enters without any control register: six read cycles to fixed addresses in a fixed order. The same five opening addresses lead both commands. The sixth address chooses between copying the array into nonvolatile cells (store) and copying the nonvolatile cells back into the array (recall). When it recognises a command, the block gives a single-clock request pulse to the transfer engine.

Chip enable and write enable are asynchronous and are synchronised to the clock. Each falling edge of the synchronised chip enable, with write enable high, counts as one read cycle, and the address is taken at that edge. A wrong address sends the matcher back to idle, unless that address is the opening address, in which case the matcher restarts one step in. One tail is reserved for factory test and produces nothing. The block also makes the data-output enable for the array. Reads drive data as normal, but the cycle that completes a command holds the outputs in high impedance until chip enable rises. While the transfer engine reports busy, no progress is kept.

Top module: `nv_cmd_detect`

## Requirements
- R1: After reset, store_req and recall_req are low, and dout_en is low while ce_n is high.
- R2: Read cycles to 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order, produce exactly one store_req pulse.
- R3: The same five opening addresses followed by 0x0F0E produce exactly one recall_req pulse.
- R4: Each request pulse is high for exactly one clock, and store_req and recall_req are never high together.
- R5: A write cycle (ce_n low with we_n low) at any point clears the progress, so finishing the remaining steps gives no pulse.
- R6: The level of oe_n has no effect on detection. A command entered with oe_n high still produces its pulse.
- R7: During reads that do not complete a command, dout_en equals (ce_n low AND we_n high AND oe_n low).
- R8: In the read cycle that completes a command, dout_en is low from the moment the sixth address is presented until ce_n rises.
- R9: The reserved tail 0x10F0 then 0x139C gives no pulse, leaves dout_en driven, and returns the matcher to idle.
- R10: An address that does not match the expected step returns the matcher to idle. If that address is 0x0000, the matcher counts it as the first step.
- R11: While busy is high, read cycles are ignored and progress is cleared, and no request pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 13 | Memory address, stable while ce_n is low |
| ce_n | input | 1 | Active-low chip enable (asynchronous) |
| we_n | input | 1 | Active-low write enable (asynchronous) |
| oe_n | input | 1 | Active-low output enable |
| busy | input | 1 | High while the transfer engine is running |
| store_req | output | 1 | One-clock request to copy the array to nonvolatile cells |
| recall_req | output | 1 | One-clock request to copy nonvolatile cells to the array |
| dout_en | output | 1 | High when the array's data outputs should drive |

## Verification
A step counter that is off by one shows up at the ports as a missing or extra request pulse a few clocks after the sixth falling edge of chip enable. It can also show up as data outputs that go high-impedance in the wrong read cycle, and that is visible in the same cycle the address is presented. A step that is not cleared after a write, a busy period or the reserved tail only shows up later, when a shortened sequence still produces a pulse. For this reason every negative case is followed by a tail-only probe or by a full sequence whose result is known. A request that does not return to idle shows up as a pulse two clocks wide, and the monitor flags that on the next clock.

// File: rtl/nv_cmd_pkg.sv
package nv_cmd_pkg;
  localparam int ADDR_W  = 13;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  localparam logic [ADDR_W-1:0] TAIL_STORE  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] TAIL_RECALL = 13'h0F0E;
  localparam logic [ADDR_W-1:0] OPEN_ADDR   = 13'h0000;

  // Address expected at a leading step (0..SEQ_LEN-2)
  function automatic logic [ADDR_W-1:0] lead_addr(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    lead_addr = OPEN_ADDR;
      3'd1:    lead_addr = 13'h1555;
      3'd2:    lead_addr = 13'h0AAA;
      3'd3:    lead_addr = 13'h1FFF;
      default: lead_addr = 13'h10F0;
    endcase
  endfunction

  function automatic logic is_cmd_tail(input logic [ADDR_W-1:0] a);
    is_cmd_tail = (a == TAIL_STORE) || (a == TAIL_RECALL);
  endfunction

  // Step reached after a mismatch: the opening address counts as step one
  function automatic logic [STEP_W-1:0] restart_step(input logic [ADDR_W-1:0] a);
    restart_step = (a == OPEN_ADDR) ? STEP_W'(1) : '0;
  endfunction
endpackage

// File: rtl/nv_sync.sv
module nv_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nv_seq_match.sv
module nv_seq_match
  import nv_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              cmd_done,
  output logic              store_req,
  output logic              recall_req
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN-1);

  logic              at_last;
  logic              hit_store, hit_recall, hit_lead;
  logic              take;
  logic [STEP_W-1:0] step_nx;

  assign at_last    = (step == LAST);
  assign take       = rd_evt && !busy && !wr_evt;
  assign hit_store  = take && at_last && (addr == TAIL_STORE);
  assign hit_recall = take && at_last && (addr == TAIL_RECALL);
  assign hit_lead   = take && !at_last && (addr == lead_addr(step));
  assign cmd_done   = hit_store || hit_recall;

  always_comb begin
    step_nx = step;
    if (busy || wr_evt)      step_nx = '0;
    else if (cmd_done)       step_nx = '0;
    else if (hit_lead)       step_nx = step + STEP_W'(1);
    else if (take)           step_nx = restart_step(addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      step       <= step_nx;
      store_req  <= hit_store;
      recall_req <= hit_recall;
    end
  end

  AST_STORE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req); // R4
  AST_RECALL_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req); // R4
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (step == '0)); // R5
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(store_req || recall_req)); // R11
  AST_REQ_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> ($past(step) == LAST)); // R2
endmodule

// File: rtl/nv_cmd_detect.sv
module nv_cmd_detect
  import nv_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req,
  output logic              dout_en
);
  logic [1:0]        ctl_s;
  logic              ce_s, we_s, ce_q;
  logic              rd_evt, wr_evt;
  logic [STEP_W-1:0] step;
  logic              cmd_done;
  logic              tail_now;
  logic              cmd_hold;

  nv_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, we_n}), .q(ctl_s)
  );
  assign ce_s = ctl_s[1];
  assign we_s = ctl_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_s;
  end

  assign rd_evt = ce_q && !ce_s && we_s;
  assign wr_evt = !ce_s && !we_s;

  nv_seq_match u_match (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .busy(busy), .step(step), .cmd_done(cmd_done),
    .store_req(store_req), .recall_req(recall_req)
  );

  // Completing cycle: outputs float while the tail is on the bus, then hold until ce rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_hold <= 1'b0;
    else if (cmd_done) cmd_hold <= 1'b1;
    else if (ce_s)     cmd_hold <= 1'b0;
  end

  assign tail_now = !busy && (step == STEP_W'(SEQ_LEN-1)) && is_cmd_tail(addr);
  assign dout_en  = !ce_n && we_n && !oe_n && !tail_now && !cmd_hold;

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req)); // R4
  AST_FLOAT_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> !dout_en); // R8
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en); // R7
endmodule

// File: tb/tb_nv_cmd_detect.sv
module tb_nv_cmd_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, busy = 1'b0;
  logic        store_req, recall_req, dout_en;

  int n_chk = 0, n_bad = 0;
  byte exp_q[$];
  logic prev_s = 1'b0, prev_r = 1'b0;

  nv_cmd_detect dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .busy(busy), .store_req(store_req), .recall_req(recall_req),
    .dout_en(dout_en)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected request kinds as pulses appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (store_req && recall_req) check("R4 both requests high", 1, 0);
      if ((store_req && prev_s) || (recall_req && prev_r)) check("R4 pulse width", 2, 1);
      if ((store_req && !prev_s) || (recall_req && !prev_r)) begin
        if (exp_q.size() == 0) check("R2/R3/R5/R9/R10/R11 unexpected pulse", store_req ? 83 : 82, 78);
        else check("R2/R3 request kind", store_req ? 83 : 82, int'(exp_q.pop_front()));
      end
      prev_s = store_req;
      prev_r = recall_req;
    end
  end

  task automatic rd(input logic [12:0] a, input bit completes, input string req);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    check({req, " dout_en early"}, dout_en, completes ? 0 : int'(!oe_n));
    repeat (5) @(negedge clk);
    check({req, " dout_en late"}, dout_en, completes ? 0 : int'(!oe_n));
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b0;
    repeat (6) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic lead5(input string req);
    rd(13'h0000, 0, req); rd(13'h1555, 0, req); rd(13'h0AAA, 0, req);
    rd(13'h1FFF, 0, req); rd(13'h10F0, 0, req);
  endtask

  task automatic settle(input string req);
    repeat (8) @(negedge clk);
    check({req, " pending expected pulses"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 store_req reset", store_req, 0);
    check("R1 recall_req reset", recall_req, 0);
    check("R1 dout_en idle", dout_en, 0);

    // R2 store, with R7 normal reads and R8 floating tail
    exp_q.push_back("S");
    lead5("R7"); rd(13'h0F0F, 1, "R8 store");
    settle("R2");

    // R3 recall
    exp_q.push_back("R");
    lead5("R7"); rd(13'h0F0E, 1, "R8 recall");
    settle("R3");

    // R6 oe_n high does not block detection
    oe_n = 1'b1;
    exp_q.push_back("S");
    lead5("R6"); rd(13'h0F0F, 1, "R6 tail");
    settle("R6");
    oe_n = 1'b0;

    // R5 write in the middle kills progress
    rd(13'h0000, 0, "R5"); rd(13'h1555, 0, "R5"); rd(13'h0AAA, 0, "R5");
    wr(13'h0AAA);
    rd(13'h1FFF, 0, "R5"); rd(13'h10F0, 0, "R5"); rd(13'h0F0F, 0, "R5 tail");
    settle("R5");
    exp_q.push_back("S");
    lead5("R5 after"); rd(13'h0F0F, 1, "R5 after tail");
    settle("R5 recovery");

    // R9 reserved test tail
    lead5("R9"); rd(13'h139C, 0, "R9 test tail");
    rd(13'h0F0F, 0, "R9 idle probe");
    settle("R9");
    exp_q.push_back("R");
    lead5("R9 after"); rd(13'h0F0E, 1, "R9 after tail");
    settle("R9 recovery");

    // R10 mismatch to idle, and 0x0000 restart
    rd(13'h0000, 0, "R10"); rd(13'h1555, 0, "R10"); rd(13'h0123, 0, "R10");
    rd(13'h0AAA, 0, "R10"); rd(13'h1FFF, 0, "R10"); rd(13'h10F0, 0, "R10");
    rd(13'h0F0F, 0, "R10 tail");
    settle("R10 mismatch");
    exp_q.push_back("S");
    rd(13'h0000, 0, "R10"); rd(13'h1555, 0, "R10");
    lead5("R10 restart"); rd(13'h0F0F, 1, "R10 restart tail");
    settle("R10 restart");
    exp_q.push_back("R");
    rd(13'h0000, 0, "R10"); rd(13'h1555, 0, "R10"); rd(13'h0AAA, 0, "R10");
    rd(13'h0000, 0, "R10"); rd(13'h1555, 0, "R10"); rd(13'h0AAA, 0, "R10");
    rd(13'h1FFF, 0, "R10"); rd(13'h10F0, 0, "R10"); rd(13'h0F0E, 1, "R10 tail2");
    settle("R10 restart mid");

    // R11 busy during whole sequence, then busy pulse mid-sequence
    busy = 1'b1;
    lead5("R11"); rd(13'h0F0F, 0, "R11 tail while busy");
    busy = 1'b0;
    settle("R11 full");
    rd(13'h0000, 0, "R11"); rd(13'h1555, 0, "R11"); rd(13'h0AAA, 0, "R11");
    @(negedge clk); busy = 1'b1;
    repeat (3) @(negedge clk); busy = 1'b0;
    rd(13'h1FFF, 0, "R11"); rd(13'h10F0, 0, "R11"); rd(13'h0F0F, 0, "R11 tail");
    settle("R11 partial");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule